// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an external asynchronous static RAM of 131,072 words by 16 bits. The host presents one command at a time over a valid/ready handshake: a word address, write data, a read-or-write flag and a per-byte lane mask. The controller turns each command into a correctly timed strobe sequence on the memory side. That sequence covers the address, the active-low chip, output and write enables, one active-low enable per byte lane, and a data bus split into out, in and drive-enable signals. A read returns its data with a single-cycle valid strobe.

All memory timing is expressed as whole clock cycles set by parameters. These cover the read wait, the write-enable pulse width, a write recovery period during which data and address are held past the end of the write, and a turnaround period after each read. The turnaround keeps the controller off the data bus until the memory has released it. A write only takes effect where chip enable, write enable and a lane enable overlap, so the lane mask selects which bytes change. Every memory-side control and the bus drive-enable come from flops, so the pins are free of glitches.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever no command is in progress, `req_ready` is 1, `rsp_valid` is 0, `mem_ce_n`, `mem_oe_n`, `mem_we_n` and every bit of `mem_be_n` are 1, and `mem_dq_oe` is 0.
- R2: A command is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 until that command has completed. A `req_valid` raised while `req_ready` is 0 is ignored and changes no memory word.
- R3: A read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD_WAIT cycles, starting the cycle after acceptance, with `mem_addr` equal to the request address and `mem_be_n` equal to the inverted mask. Mask bit 0 selects lane bits 7..0 and mask bit 1 selects bits 15..8. `mem_dq_oe` stays 0 throughout.
- R4: The read data is sampled at the end of the last read-wait cycle. It is presented on `rsp_rdata` with `rsp_valid`=1 for exactly one cycle, the cycle after the last wait cycle. Lanes whose mask bit is 0 read as zero.
- R5: A write holds `mem_ce_n`=0, `mem_we_n`=0 and `mem_oe_n`=1 for exactly WR_PULSE cycles, starting the cycle after acceptance. During those cycles `mem_be_n` equals the inverted mask and `mem_dq_oe`=1, with `mem_dq_out` equal to the write data and `mem_addr` equal to the request address.
- R6: After the write pulse, for WR_RECOV cycles, `mem_we_n`, `mem_ce_n` and all of `mem_be_n` are 1. Over the same cycles `mem_dq_oe` stays 1 and `mem_dq_out` and `mem_addr` keep their write values. Only after this does `req_ready` return to 1 with the bus released.
- R7: A write changes only the byte lanes whose mask bit is 1. The other lane of that word keeps its previous contents.
- R8: After a read, `mem_oe_n` is 1 and `mem_dq_oe` is 0 for at least TURN_CYC cycles before `req_ready` returns. `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R9: A write with an all-zero mask modifies no memory byte. A read with an all-zero mask returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host command valid |
| req_ready | output | 1 | Controller can take a command |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 = bits 7..0, bit 1 = bits 15..8 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, deselected lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_be_n | output | 2 | Memory lane enables, active low |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_in | input | 16 | Data from memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |

## Verification
The bench builds the controller with RD_WAIT=3, WR_PULSE=2, WR_RECOV=2 and TURN_CYC=2, rather than the 100 MHz defaults of 2, 1, 1 and 1. This way every timed phase spans several cycles and the cycle-exact length of each phase can be measured against its own parameter. The memory model drives a filler byte on any lane that is not enabled, so a capture that ignores the mask becomes visible. The model also flags any cycle in which both sides drive the bus. Scenarios include a write followed at once by a read, and a read followed at once by a write, which exercises the turnaround gap. A command offered while the controller is busy is also covered.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_TURN,
      ST_WP,
      ST_WREC
   } seq_st_e;

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

   // bits to hold values 0 .. n-1, never below one
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
   import sram_lane_pkg::*;
#(
   parameter int unsigned LANES    = 2,
   parameter int unsigned RD_WAIT  = 2,
   parameter int unsigned WR_PULSE = 1,
   parameter int unsigned WR_RECOV = 1,
   parameter int unsigned TURN_CYC = 1,
   parameter int unsigned CNT_W    = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [LANES-1:0] sel_mask,
   output logic             req_ready,
   output logic             cap_en,
   output logic             ce_n,
   output logic             oe_n,
   output logic             we_n,
   output logic [LANES-1:0] be_n,
   output logic             dq_oe
);

   localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_WAIT - 1);
   localparam logic [CNT_W-1:0] LD_WP   = CNT_W'(WR_PULSE - 1);
   localparam logic [CNT_W-1:0] LD_WREC = CNT_W'(WR_RECOV - 1);
   localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(TURN_CYC - 1);

   seq_st_e          st_q, st_d;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_done;
   logic             fire;

   assign req_ready = (st_q == ST_IDLE);
   assign fire      = req_valid && req_ready;

   sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      cap_en   = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (fire) begin
               tmr_load = 1'b1;
               if (req_write) begin
                  st_d    = ST_WP;
                  tmr_val = LD_WP;
               end else begin
                  st_d    = ST_RD;
                  tmr_val = LD_RD;
               end
            end
         end
         ST_RD: begin
            if (tmr_done) begin
               cap_en   = 1'b1;
               st_d     = ST_TURN;
               tmr_load = 1'b1;
               tmr_val  = LD_TURN;
            end
         end
         ST_TURN: begin
            if (tmr_done) st_d = ST_IDLE;
         end
         ST_WP: begin
            if (tmr_done) begin
               st_d     = ST_WREC;
               tmr_load = 1'b1;
               tmr_val  = LD_WREC;
            end
         end
         ST_WREC: begin
            if (tmr_done) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   // pins follow the next state so they switch on the same edge, from flops
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_n  <= 1'b1;
         oe_n  <= 1'b1;
         we_n  <= 1'b1;
         be_n  <= '1;
         dq_oe <= 1'b0;
      end else begin
         ce_n  <= !((st_d == ST_RD) || (st_d == ST_WP));
         oe_n  <= (st_d != ST_RD);
         we_n  <= (st_d != ST_WP);
         be_n  <= ((st_d == ST_RD) || (st_d == ST_WP)) ? ~sel_mask : '1;
         dq_oe <= (st_d == ST_WP) || (st_d == ST_WREC);
      end
   end

   a_r1_ready_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (ce_n && oe_n && we_n && !dq_oe));

   a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r3_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> (!ce_n && we_n));

   a_r5_write_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (!ce_n && oe_n && dq_oe));

   a_r8_no_drive_when_oe: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> oe_n);

   a_r8_release_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_n) |-> !dq_oe);

endmodule

// File: rtl/sram_lane_rdcap.sv
module sram_lane_rdcap #(
   parameter int unsigned LANES  = 2,
   parameter int unsigned LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cap_en,
   input  logic [LANES-1:0]        mask,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic                    rsp_valid,
   output logic [LANES*LANE_W-1:0] rsp_rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsp_valid <= 1'b0;
      else        rsp_valid <= cap_en;
   end

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_rdata[ln*LANE_W +: LANE_W] <= '0;
         end else if (cap_en) begin
            rsp_rdata[ln*LANE_W +: LANE_W] <= mask[ln] ? dq_in[ln*LANE_W +: LANE_W] : '0;
         end
      end

      a_r4_masked_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid && !mask[ln]) |-> (rsp_rdata[ln*LANE_W +: LANE_W] == '0));
   end

   a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int unsigned ADDR_W   = 17,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned LANE_W   = 8,
   parameter int unsigned RD_WAIT  = 2,
   parameter int unsigned WR_PULSE = 1,
   parameter int unsigned WR_RECOV = 1,
   parameter int unsigned TURN_CYC = 1,
   localparam int unsigned LANES   = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_mask,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [LANES-1:0]  mem_be_n,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe
);

   localparam int unsigned MAX_CNT = max4(RD_WAIT, WR_PULSE, WR_RECOV, TURN_CYC);
   localparam int unsigned CNT_W   = cnt_width(MAX_CNT);

   if (LANE_W == 0 || (DATA_W % LANE_W) != 0) begin : g_bad_lane
      $error("DATA_W must be a whole number of lanes");
   end
   if (RD_WAIT < 1 || WR_PULSE < 1 || WR_RECOV < 1 || TURN_CYC < 1) begin : g_bad_wait
      $error("every wait count must be at least one cycle");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be positive");
   end

   logic              fire;
   logic              cap_en;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  mask_q;
   logic [LANES-1:0]  sel_mask;

   assign fire     = req_valid && req_ready;
   assign sel_mask = fire ? req_mask : mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         mask_q  <= '0;
      end else if (fire) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         mask_q  <= req_mask;
      end
   end

   assign mem_addr   = addr_q;
   assign mem_dq_out = wdata_q;

   sram_lane_seq #(
      .LANES    (LANES),
      .RD_WAIT  (RD_WAIT),
      .WR_PULSE (WR_PULSE),
      .WR_RECOV (WR_RECOV),
      .TURN_CYC (TURN_CYC),
      .CNT_W    (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .sel_mask  (sel_mask),
      .req_ready (req_ready),
      .cap_en    (cap_en),
      .ce_n      (mem_ce_n),
      .oe_n      (mem_oe_n),
      .we_n      (mem_we_n),
      .be_n      (mem_be_n),
      .dq_oe     (mem_dq_oe)
   );

   sram_lane_rdcap #(
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_rdcap (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (cap_en),
      .mask      (mask_q),
      .dq_in     (mem_dq_in),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   a_r6_hold_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out) && $stable(mem_addr)));

   a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   a_r2_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !mem_ce_n) |=> $stable(mem_addr));

endmodule

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;

   localparam int CLK_NS   = 10;
   localparam int A_W      = 17;
   localparam int D_W      = 16;
   localparam int RD_WAIT  = 3;
   localparam int WR_PULSE = 2;
   localparam int WR_RECOV = 2;
   localparam int TURN_CYC = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_ready;
   logic           req_write = 1'b0;
   logic [A_W-1:0] req_addr = '0;
   logic [D_W-1:0] req_wdata = '0;
   logic [1:0]     req_mask = '0;
   logic           rsp_valid;
   logic [D_W-1:0] rsp_rdata;
   logic [A_W-1:0] mem_addr;
   logic           mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [1:0]     mem_be_n;
   logic [D_W-1:0] mem_dq_out;
   logic [D_W-1:0] mem_dq_in;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int contention = 0;
   int last_oe_cyc = -1;
   int min_gap = 1000;
   bit prev_dq_oe = 1'b0;
   bit finished = 1'b0;

   logic [D_W-1:0] mdl   [logic [A_W-1:0]];
   logic [D_W-1:0] ref_m [logic [A_W-1:0]];

   always #(CLK_NS/2) clk = ~clk;

   sram_lane_ctrl #(
      .ADDR_W(A_W), .DATA_W(D_W), .LANE_W(8),
      .RD_WAIT(RD_WAIT), .WR_PULSE(WR_PULSE), .WR_RECOV(WR_RECOV), .TURN_CYC(TURN_CYC)
   ) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
   );

   function automatic logic [D_W-1:0] mdl_get(input logic [A_W-1:0] a);
      return mdl.exists(a) ? mdl[a] : '0;
   endfunction

   function automatic logic [D_W-1:0] ref_get(input logic [A_W-1:0] a);
      return ref_m.exists(a) ? ref_m[a] : '0;
   endfunction

   function automatic logic [D_W-1:0] lmask(input logic [1:0] m);
      return {{8{m[1]}}, {8{m[0]}}};
   endfunction

   // memory model: drives a lane only when selected for reading, filler otherwise
   always_comb begin
      logic [D_W-1:0] cur;
      cur = mdl_get(mem_addr);
      for (int l = 0; l < 2; l++) begin
         mem_dq_in[l*8 +: 8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[l])
                               ? cur[l*8 +: 8] : 8'hEE;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (!mem_ce_n && !mem_we_n) begin
            logic [D_W-1:0] w;
            w = mdl_get(mem_addr);
            for (int l = 0; l < 2; l++)
               if (!mem_be_n[l]) w[l*8 +: 8] = mem_dq_out[l*8 +: 8];
            mdl[mem_addr] = w;
         end
         if (mem_dq_oe && !mem_ce_n && !mem_oe_n && mem_we_n) contention++;
         if (!mem_oe_n) last_oe_cyc = cyc;
         if (mem_dq_oe && !prev_dq_oe && last_oe_cyc >= 0 && (cyc - last_oe_cyc - 1) < min_gap)
            min_gap = cyc - last_oe_cyc - 1;
         prev_dq_oe = mem_dq_oe;
      end
   end

   always @(posedge clk) cyc++;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic ref_put(input logic [A_W-1:0] a, input logic [D_W-1:0] d, input logic [1:0] m);
      ref_m[a] = (ref_get(a) & ~lmask(m)) | (d & lmask(m));
   endtask

   task automatic issue(input bit w, input logic [A_W-1:0] a, input logic [D_W-1:0] d, input logic [1:0] m);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_write(input logic [A_W-1:0] a, input logic [D_W-1:0] d, input logic [1:0] m);
      issue(1'b1, a, d, m);
      for (int i = 0; i < WR_PULSE; i++) begin
         chk(!mem_ce_n && !mem_we_n && mem_oe_n, "R5 strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b010);
         chk(mem_be_n == ~m && mem_dq_oe && mem_dq_out == d && mem_addr == a, "R5 lanes/data",
             {mem_be_n, mem_dq_oe, mem_dq_out}, {~m, 1'b1, d});
         @(negedge clk);
      end
      for (int i = 0; i < WR_RECOV; i++) begin
         chk(mem_we_n && mem_ce_n && mem_be_n == 2'b11 && mem_dq_oe && mem_dq_out == d && mem_addr == a,
             "R6 recovery", {mem_we_n, mem_ce_n, mem_be_n, mem_dq_oe}, 5'b11111);
         chk(!req_ready, "R2 busy in recovery", req_ready, 0);
         @(negedge clk);
      end
      chk(req_ready && !mem_dq_oe && mem_ce_n && mem_we_n && mem_be_n == 2'b11, "R1 idle after write",
          {req_ready, mem_dq_oe, mem_ce_n}, 3'b101);
      ref_put(a, d, m);
   endtask

   task automatic do_read(input logic [A_W-1:0] a, input logic [1:0] m, input string tag);
      logic [D_W-1:0] exp;
      exp = ref_get(a) & lmask(m);
      issue(1'b0, a, '0, m);
      for (int i = 0; i < RD_WAIT; i++) begin
         chk(!mem_ce_n && !mem_oe_n && mem_we_n && mem_be_n == ~m && mem_addr == a && !mem_dq_oe,
             "R3 read strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n}, {3'b001, ~m});
         chk(!rsp_valid, "R4 early strobe", rsp_valid, 0);
         @(negedge clk);
      end
      chk(rsp_valid, "R4 strobe", rsp_valid, 1);
      chk(rsp_rdata == exp, tag, rsp_rdata, exp);
      for (int i = 0; i < TURN_CYC; i++) begin
         chk(!req_ready && mem_oe_n && !mem_dq_oe, "R8 turnaround", {req_ready, mem_oe_n, mem_dq_oe}, 3'b010);
         @(negedge clk);
      end
      chk(req_ready && !rsp_valid, "R4 single strobe", {req_ready, rsp_valid}, 2'b10);
   endtask

   task automatic t_reset;
      chk(mem_ce_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && !mem_dq_oe, "R1 in reset",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe}, 6'b111110);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 after reset",
          {req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 6'b101110);
   endtask

   task automatic t_words;
      do_write(17'h00000, 16'hA5C3, 2'b11);
      do_write(17'h1FFFF, 16'h0FF0, 2'b11);
      do_write(17'h12345, 16'hFFFF, 2'b11);
      do_read(17'h00000, 2'b11, "R4 word low addr");
      do_read(17'h1FFFF, 2'b11, "R4 word top addr");
      do_read(17'h12345, 2'b11, "R4 word all ones");
   endtask

   task automatic t_bytes;
      do_write(17'h00100, 16'h1122, 2'b11);
      do_write(17'h00100, 16'hAABB, 2'b01);
      do_read(17'h00100, 2'b11, "R7 lower lane only");
      do_write(17'h00100, 16'hCCDD, 2'b10);
      do_read(17'h00100, 2'b11, "R7 upper lane only");
      do_read(17'h00100, 2'b01, "R4 lower masked read");
      do_read(17'h00100, 2'b10, "R4 upper masked read");
   endtask

   task automatic t_empty;
      do_write(17'h00200, 16'h5A5A, 2'b11);
      do_write(17'h00200, 16'h0000, 2'b00);
      do_read(17'h00200, 2'b11, "R9 empty write kept word");
      do_read(17'h00200, 2'b00, "R9 empty read zero");
   endtask

   task automatic t_turn;
      min_gap = 1000;
      do_read(17'h00100, 2'b11, "R4 read before write");
      do_write(17'h00300, 16'h7E81, 2'b11);
      chk(min_gap >= TURN_CYC, "R8 gap before drive", min_gap, TURN_CYC);
      chk(contention == 0, "R8 bus contention", contention, 0);
      do_read(17'h00300, 2'b11, "R4 read after write");
   endtask

   task automatic t_busy;
      do_write(17'h00400, 16'h1357, 2'b11);
      issue(1'b1, 17'h00401, 16'h2468, 2'b11);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00400; req_wdata = 16'hDEAD; req_mask = 2'b11;
      chk(!req_ready, "R2 ready low while busy", req_ready, 0);
      @(negedge clk);
      req_valid = 1'b0;
      while (!req_ready) @(negedge clk);
      ref_put(17'h00401, 16'h2468, 2'b11);
      do_read(17'h00400, 2'b11, "R2 busy command ignored");
      do_read(17'h00401, 2'b11, "R2 accepted write landed");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_words();
      t_bytes();
      t_empty();
      t_turn();
      t_busy();
      chk(contention == 0, "R8 no contention overall", contention, 0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule